// File: doc/BRIEF.md
# Completion Response Queue with Read-to-Pop Window

This block holds one completion record for each descriptor that a transfer engine finishes. A record carries the number of bytes moved, an 8-bit error code and a flag that marks early termination. Records arrive over a valid/ready stream and wait in a circular buffer until software collects them.

Software collects records through a two-word register window. The word at offset 0x00 returns the head record's byte count and has no side effect. The word at offset 0x04 returns the head record's status and removes that record from the queue. Software reads the byte count first and the status last for each record. The block also drives empty and full flags and a 32-bit fill-level word, which the control and status bank places in its registers. A sticky overflow flag records that a completion was lost.

Back-pressure rules for the completion stream: `cpl_ready` is high exactly when the queue is not full. A beat is taken on a clock edge where both `cpl_valid` and `cpl_ready` are high. The producer is not required to hold a beat while `cpl_ready` is low. Such a beat is discarded, and the overflow flag is set. A pop in the same cycle does not make room for a beat offered while the queue is full, because `cpl_ready` depends only on the registered fill level.

Top module: `cpl_resp_queue`

## Requirements
- R1: After reset the queue is empty: `resp_fill` is 0, `resp_empty` is 1, `resp_full` is 0, `resp_ovf` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A read at offset 0x00 returns the head record's byte count, zero-extended to 32 bits, one cycle later with `rd_valid` high. It does not remove the record, so repeated reads return the same value.
- R3: A read at offset 0x04 returns the head status word one cycle later. Bits 7:0 hold the error code, bit 8 holds the early-termination flag, and all other bits are 0. The read removes the head record.
- R4: Records are returned in the order in which they were accepted.
- R5: `resp_fill` reports the number of stored records in its low bits, and bits 31:16 are always 0.
- R6: `resp_empty` is high exactly when the fill level is 0, and `resp_full` is high exactly when the fill level equals DEPTH.
- R7: A completion offered while the queue is full is dropped, and the fill level and stored records do not change. `resp_ovf` rises on the next cycle and stays high until reset.
- R8: A read at either offset while the queue is empty returns 0 and removes nothing.
- R9: An accepted completion and a status read in the same cycle leave the fill level unchanged, and the new record is placed behind all records already stored.
- R10: A read at any offset other than 0x00 or 0x04 returns 0 and removes nothing.
- R11: DEPTH is a parameter (default 16), and the fill level is wide enough to represent DEPTH itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid | input | 1 | Completion beat offered |
| cpl_ready | output | 1 | Queue can take a beat (not full) |
| cpl_bytes | input | BYTES_W | Bytes moved by the finished descriptor |
| cpl_err | input | 8 | Error code of the finished descriptor |
| cpl_early | input | 1 | Descriptor ended early |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| resp_empty | output | 1 | No records stored |
| resp_full | output | 1 | DEPTH records stored |
| resp_fill | output | 32 | Fill level, bits 31:16 zero |
| resp_ovf | output | 1 | Sticky: a completion was dropped |

## Verification
The bench fills the queue to its limit and offers one more completion. A design that overwrote a slot or advanced a pointer there would return a corrupted record order when the queue is drained. It reads the byte-count word several times before reading the status word. A design that popped on the wrong offset would skip records and show the wrong fill level. It reads the queue while it is empty and at unmapped offsets, where a missing guard would return stale data or underflow the count. It also issues a push and a status read in the same cycle, both below the limit and at the limit. A design that updated the count or the write slot wrongly there would show a drifting fill level or records that arrive out of order.

// File: rtl/cpl_resp_pkg.sv
package cpl_resp_pkg;

  localparam int ERR_W      = 8;
  localparam int WORD_W     = 32;
  localparam int OFS_BYTES  = 0;
  localparam int OFS_STATUS = 4;

  typedef struct packed {
    logic             early;
    logic [ERR_W-1:0] err;
  } cpl_status_t;

  localparam int STAT_W = $bits(cpl_status_t);

  typedef enum logic [1:0] {
    WSEL_BYTES,
    WSEL_STATUS,
    WSEL_NONE
  } win_sel_e;

  function automatic logic [WORD_W-1:0] pack_status(cpl_status_t s);
    return {{(WORD_W-STAT_W){1'b0}}, s.early, s.err};
  endfunction

endpackage

// File: rtl/cpl_resp_ingress.sv
module cpl_resp_ingress (
  input  logic clk,
  input  logic rst_n,
  input  logic cpl_valid,
  input  logic full,
  output logic cpl_ready,
  output logic accept,
  output logic ovf
);

  logic ovf_q;

  assign cpl_ready = ~full;
  assign accept    = cpl_valid & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (cpl_valid && full) begin
      ovf_q <= 1'b1;
    end
  end

  assign ovf = ovf_q;

endmodule

// File: rtl/cpl_resp_store.sv
module cpl_resp_store
  import cpl_resp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int BYTES_W = 32,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [BYTES_W-1:0] push_bytes,
  input  cpl_status_t        push_stat,
  input  logic               pop,
  output logic [BYTES_W-1:0] head_bytes,
  output cpl_status_t        head_stat,
  output logic [LVL_W-1:0]   level,
  output logic               empty,
  output logic               full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] CAP  = LVL_W'(DEPTH);

  logic [BYTES_W-1:0] mem_bytes [DEPTH];
  cpl_status_t        mem_stat  [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [LVL_W-1:0]   cnt;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem_bytes[wr_ptr] <= push_bytes;
      mem_stat[wr_ptr]  <= push_stat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_bytes = mem_bytes[rd_ptr];
  assign head_stat  = mem_stat[rd_ptr];
  assign level      = cnt;
  assign empty      = (cnt == '0);
  assign full       = (cnt == CAP);

endmodule

// File: rtl/cpl_resp_window.sv
module cpl_resp_window
  import cpl_resp_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int BYTES_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               empty,
  input  logic [BYTES_W-1:0] head_bytes,
  input  cpl_status_t        head_stat,
  output logic               pop,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data
);

  win_sel_e          sel;
  logic [WORD_W-1:0] bytes_word;
  logic [WORD_W-1:0] next_word;

  generate
    if (BYTES_W < WORD_W) begin : g_zext
      assign bytes_word = {{(WORD_W-BYTES_W){1'b0}}, head_bytes};
    end else begin : g_full
      assign bytes_word = head_bytes[WORD_W-1:0];
    end
  endgenerate

  always_comb begin
    if (rd_addr == ADDR_W'(OFS_BYTES))       sel = WSEL_BYTES;
    else if (rd_addr == ADDR_W'(OFS_STATUS)) sel = WSEL_STATUS;
    else                                     sel = WSEL_NONE;
  end

  always_comb begin
    next_word = '0;
    if (!empty) begin
      unique case (sel)
        WSEL_BYTES:  next_word = bytes_word;
        WSEL_STATUS: next_word = pack_status(head_stat);
        default:     next_word = '0;
      endcase
    end
  end

  assign pop = rd_en & ~empty & (sel == WSEL_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= next_word;
    end
  end

endmodule

// File: rtl/cpl_resp_queue.sv
module cpl_resp_queue
  import cpl_resp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int BYTES_W = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpl_valid,
  output logic               cpl_ready,
  input  logic [BYTES_W-1:0] cpl_bytes,
  input  logic [ERR_W-1:0]   cpl_err,
  input  logic               cpl_early,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data,
  output logic               resp_empty,
  output logic               resp_full,
  output logic [WORD_W-1:0]  resp_fill,
  output logic               resp_ovf
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  logic               accept, pop;
  logic [BYTES_W-1:0] head_bytes;
  cpl_status_t        head_stat, in_stat;
  logic [LVL_W-1:0]   level;

  assign in_stat.early = cpl_early;
  assign in_stat.err   = cpl_err;

  cpl_resp_ingress u_ingress (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpl_valid (cpl_valid),
    .full      (resp_full),
    .cpl_ready (cpl_ready),
    .accept    (accept),
    .ovf       (resp_ovf)
  );

  cpl_resp_store #(
    .DEPTH   (DEPTH),
    .BYTES_W (BYTES_W),
    .LVL_W   (LVL_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (accept),
    .push_bytes (cpl_bytes),
    .push_stat  (in_stat),
    .pop        (pop),
    .head_bytes (head_bytes),
    .head_stat  (head_stat),
    .level      (level),
    .empty      (resp_empty),
    .full       (resp_full)
  );

  cpl_resp_window #(
    .ADDR_W  (ADDR_W),
    .BYTES_W (BYTES_W)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .empty      (resp_empty),
    .head_bytes (head_bytes),
    .head_stat  (head_stat),
    .pop        (pop),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign resp_fill = WORD_W'(level);

endmodule

// File: rtl/cpl_resp_queue_chk.sv
module cpl_resp_queue_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              resp_empty,
  input logic              resp_full,
  input logic [31:0]       resp_fill,
  input logic              resp_ovf
);

  logic stat_rd, bytes_rd;
  assign stat_rd  = rd_en && (rd_addr == ADDR_W'(4));
  assign bytes_rd = rd_en && (rd_addr == ADDR_W'(0));

  // R6
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_empty && resp_full));

  // R6
  a_r6_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
    resp_empty == (resp_fill == 32'd0));

  // R7
  a_r7_ready_tracks_full: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_ready == !resp_full);

  // R7
  a_r7_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && resp_full && !stat_rd) |=> (resp_full && $stable(resp_fill)));

  // R7
  a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && resp_full) |=> resp_ovf);

  // R7
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ovf |=> resp_ovf);

  // R8
  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && resp_empty) |=> (rd_valid && rd_data == 32'd0));

  // R2
  a_r2_bytes_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_rd && !cpl_valid) |=> $stable(resp_fill));

  // R3
  a_r3_status_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !resp_empty && !cpl_valid) |=> (resp_fill == $past(resp_fill) - 32'd1));

  // R9
  a_r9_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !resp_empty && cpl_valid && !resp_full) |=> $stable(resp_fill));

endmodule

bind cpl_resp_queue cpl_resp_queue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpl_valid  (cpl_valid),
  .cpl_ready  (cpl_ready),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .resp_empty (resp_empty),
  .resp_full  (resp_full),
  .resp_fill  (resp_fill),
  .resp_ovf   (resp_ovf)
);

// File: tb/cpl_resp_queue_tb.sv
module cpl_resp_queue_tb;

  localparam int DEPTH  = 4;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpl_valid = 1'b0;
  logic              cpl_ready;
  logic [31:0]       cpl_bytes = '0;
  logic [7:0]        cpl_err = '0;
  logic              cpl_early = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic              resp_empty, resp_full, resp_ovf;
  logic [31:0]       resp_fill;

  always #2 clk = ~clk;

  cpl_resp_queue #(.DEPTH(DEPTH), .BYTES_W(32), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_bytes(cpl_bytes), .cpl_err(cpl_err), .cpl_early(cpl_early),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .resp_empty(resp_empty), .resp_full(resp_full),
    .resp_fill(resp_fill), .resp_ovf(resp_ovf)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit ovf_m = 0;

  logic [31:0] m_bytes [$];
  logic [31:0] m_stat  [$];
  logic [31:0] exp_rd  [$];
  string       exp_tag [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " fill"},  resp_fill, 32'(m_bytes.size()));
    chk({tag, " empty"}, 32'(resp_empty), 32'(m_bytes.size() == 0));
    chk({tag, " full"},  32'(resp_full),  32'(m_bytes.size() == DEPTH));
    chk({tag, " ready"}, 32'(cpl_ready),  32'(m_bytes.size() < DEPTH));
    chk({tag, " ovf"},   32'(resp_ovf),   32'(ovf_m));
  endtask

  // Driver: offer a completion and record what the queue should hold.
  task automatic push_cpl(logic [31:0] b, logic [7:0] e, logic early);
    cpl_valid = 1'b1; cpl_bytes = b; cpl_err = e; cpl_early = early;
    if (m_bytes.size() < DEPTH) begin
      m_bytes.push_back(b);
      m_stat.push_back({23'b0, early, e});
    end else begin
      ovf_m = 1'b1;
    end
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  function automatic logic [31:0] model_read(logic [ADDR_W-1:0] a);
    logic [31:0] v;
    v = 32'd0;
    if (m_bytes.size() != 0) begin
      if (a == ADDR_W'(0)) v = m_bytes[0];
      else if (a == ADDR_W'(4)) begin
        v = m_stat[0];
        void'(m_bytes.pop_front());
        void'(m_stat.pop_front());
      end
    end
    return v;
  endfunction

  task automatic rd(logic [ADDR_W-1:0] a, string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_rd.push_back(model_read(a));
    exp_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Push and status read in the same cycle; ready reflects the level before the pop.
  task automatic push_pop(logic [31:0] b, logic [7:0] e, logic early, string tag);
    bit room;
    room = (m_bytes.size() < DEPTH);
    cpl_valid = 1'b1; cpl_bytes = b; cpl_err = e; cpl_early = early;
    rd_en = 1'b1; rd_addr = ADDR_W'(4);
    exp_rd.push_back(model_read(ADDR_W'(4)));
    exp_tag.push_back(tag);
    if (room) begin
      m_bytes.push_back(b);
      m_stat.push_back({23'b0, early, e});
    end else begin
      ovf_m = 1'b1;
    end
    @(negedge clk);
    cpl_valid = 1'b0; rd_en = 1'b0;
  endtask

  // Monitor: compare each returned read with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_rd.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual unexpected read %h expected none", rd_data);
      end else begin
        chk(exp_tag.pop_front(), rd_data, exp_rd.pop_front());
      end
    end
  end

  task automatic drain(string tag);
    while (m_bytes.size() != 0) begin
      rd(ADDR_W'(0), tag);
      rd(ADDR_W'(4), tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_state("R1");
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);

    // R8 reads while empty
    rd(ADDR_W'(0), "R8 empty bytes");
    rd(ADDR_W'(4), "R8 empty status");
    chk_state("R8");

    // R5 R6 partial fill
    push_cpl(32'h0000_0040, 8'h00, 1'b0);
    push_cpl(32'h1234_5678, 8'h5A, 1'b1);
    push_cpl(32'hFFFF_FFFF, 8'hFF, 1'b1);
    chk_state("R5");
    chk("R5 upper zero", {16'b0, resp_fill[31:16]}, 32'd0);

    // R2 repeated byte reads do not pop
    rd(ADDR_W'(0), "R2 bytes");
    rd(ADDR_W'(0), "R2 bytes again");
    chk_state("R2");
    // R3 status read pops
    rd(ADDR_W'(4), "R3 status");
    chk_state("R3");

    // R10 unmapped offsets
    rd(ADDR_W'(8), "R10 offset8");
    rd(ADDR_W'(12), "R10 offset12");
    rd(ADDR_W'(2), "R10 offset2");
    chk_state("R10");

    // R9 push and pop together below the limit
    push_pop(32'h0000_0A0A, 8'h01, 1'b0, "R9 status");
    chk_state("R9");

    // R6 R7 fill to the limit and overflow
    push_cpl(32'h0000_0B0B, 8'h02, 1'b0);
    push_cpl(32'h0000_0C0C, 8'h03, 1'b1);
    chk_state("R6 full");
    push_cpl(32'hDEAD_BEEF, 8'hEE, 1'b1);
    chk_state("R7 dropped");

    // R9 push and pop at the limit: push is refused
    push_pop(32'hBAD0_0001, 8'h44, 1'b0, "R9 at full");
    chk_state("R9 full");

    // R4 drain in order
    drain("R4 order");
    chk_state("R7 sticky");

    // R4 R11 fill again and drain
    for (int i = 0; i < DEPTH; i++) push_cpl(32'(100 + i), 8'(i * 3), i[0]);
    chk_state("R11 depth");
    drain("R4 refill order");
    chk_state("R4 end");

    repeat (3) @(negedge clk);
    chk("R2 pending reads", 32'(exp_rd.size()), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule